// File: doc/BRIEF.md
# Atomic Bit-Operation Register

This block holds one peripheral register, such as the output latch of a bank of general-purpose pins. Besides the plain register word, three write-only alias words sit next to it in the address map. A write to an alias does not store the written value. It combines the value with the current register contents. One alias clears the bits set in the value, one sets them and one toggles them. Software can then change a few bits in a single bus write. It has no read-modify-write sequence that an interrupt service routine could split, and other users of the same register keep their bits.

The register contents leave the block as a parallel output. A small memory-mapped slave port accepts a word address, a write enable, write data and returns read data. A write is applied once for each rising edge of the write enable. A master that holds the enable high for several cycles still causes only one update. This matters most for the toggle alias.

Top module: `bitop_reg`

## Requirements
- R1: While reset is asserted and after it is released, the register output is all zeros until the first accepted write.
- R2: A write to the base word (word offset 0 from `BASE_WORD`) stores the write data directly in the register on the next clock edge.
- R3: A write to word offset 1 (the clear alias) makes the register equal to its previous value AND NOT the write data.
- R4: A write to word offset 2 (the set alias, 8 bytes above the base) makes the register equal to its previous value OR the write data.
- R5: A write to word offset 3 (the toggle alias) makes the register equal to its previous value XOR the write data.
- R6: A write to any alias leaves unchanged every register bit whose write-data bit is zero.
- R7: A write takes effect only in the cycle that follows a rising edge of `wr_en`. Holding `wr_en` high for further cycles causes no further update.
- R8: Read data equals the register when the address is the base word. It is zero when the address is one of the three aliases or lies outside the block.
- R9: A write to an address whose upper bits (all but the lowest two) differ from those of `BASE_WORD` leaves the register unchanged.
- R10: Without an accepted write the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| addr | input | ADDR_W | Word address of the access |
| wr_en | input | 1 | Write enable; its rising edge marks one write |
| wr_data | input | DATA_W | Write data or bit mask |
| rd_data | output | DATA_W | Read data, combinational from addr |
| reg_out | output | DATA_W | Current register contents |

## Verification
The assertions assume that a master drops `wr_en` between two writes. They also assume that `addr` and `wr_data` are stable during the cycle in which a write is accepted. The stimulus always returns the enable low after each write. It changes address and data only together with a new enable edge. One write keeps the enable high for several cycles on the toggle alias, so that the single-update rule is exercised. Further writes go to addresses outside the block and to every alias with patterns that mix touched and untouched bits.

// File: rtl/bitop_reg_pkg.sv
package bitop_reg_pkg;
  // Word offset within the four-word window selects the operation
  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SET   = 2'd2,
    OP_FLIP  = 2'd3
  } bitop_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/bitop_reg_decode.sv
module bitop_reg_decode
  import bitop_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_WORD = 12'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              hit,
  output bitop_e            op,
  output logic              wr_pulse
);
  logic en_q, en_d;

  always_comb begin
    hit = (addr[ADDR_W-1:SEL_W] == BASE_WORD[ADDR_W-1:SEL_W]);
    op  = bitop_e'(addr[SEL_W-1:0]);
    en_d = wr_en;
    wr_pulse = wr_en & ~en_q & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  AST_SINGLE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R7
  AST_HELD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> !wr_pulse); // R7
endmodule

// File: rtl/bitop_reg_alu.sv
module bitop_reg_alu
  import bitop_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  bitop_e            op,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] nxt
);
  always_comb begin
    unique case (op)
      OP_STORE: nxt = mask;
      OP_CLEAR: nxt = cur & ~mask;
      OP_SET:   nxt = cur | mask;
      OP_FLIP:  nxt = cur ^ mask;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bitop_reg.sv
module bitop_reg
  import bitop_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_WORD = 12'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] reg_out
);
  logic              hit;
  bitop_e            op;
  logic              wr_pulse;
  logic [DATA_W-1:0] val_q, val_d;

  bitop_reg_decode #(.ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .hit(hit), .op(op), .wr_pulse(wr_pulse)
  );

  bitop_reg_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .cur(val_q), .mask(wr_data), .nxt(val_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        val_q <= '0;
    else if (wr_pulse) val_q <= val_d;
  end

  always_comb begin
    reg_out = val_q;
    rd_data = (hit && op == OP_STORE) ? val_q : '0;
  end

  AST_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && op == OP_STORE) |=> reg_out == $past(wr_data)); // R2
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && op == OP_CLEAR) |=> (reg_out & $past(wr_data)) == '0); // R3
  AST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && op == OP_SET) |=> (reg_out & $past(wr_data)) == $past(wr_data)); // R4
  AST_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && op == OP_FLIP) |=> reg_out == ($past(reg_out) ^ $past(wr_data))); // R5
  AST_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && op != OP_STORE) |=>
      ((reg_out ^ $past(reg_out)) & ~$past(wr_data)) == '0); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(reg_out)); // R10
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_STORE || !hit) |-> rd_data == '0); // R8
endmodule

// File: tb/tb_bitop_reg.sv
module tb_bitop_reg;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] BASE = 12'h040;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data, reg_out;

  int tests = 0;
  int fails = 0;
  logic          started = 1'b0;
  logic [DW-1:0] model = '0;
  logic          prev_en = 1'b0;
  string         tag = "R1";

  always #5 clk = ~clk;

  bitop_reg #(.DATA_W(DW), .ADDR_W(AW), .BASE_WORD(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .reg_out(reg_out)
  );

  // Behavioural reference: one update per enable rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model   <= '0;
      prev_en <= 1'b0;
    end else begin
      prev_en <= wr_en;
      if (wr_en && !prev_en && (addr >> 2) == (BASE >> 2)) begin
        case (addr % 4)
          0: model <= wr_data;
          1: model <= model & ~wr_data;
          2: model <= model | wr_data;
          default: model <= model ^ wr_data;
        endcase
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      logic [DW-1:0] exp_rd;
      exp_rd = (addr == BASE) ? model : '0;
      tests++;
      if (reg_out !== model) begin
        fails++;
        $display("FAIL %s reg_out actual=%h expected=%h", tag, reg_out, model);
      end
      tests++;
      if (rd_data !== exp_rd) begin
        fails++;
        $display("FAIL R8 rd_data actual=%h expected=%h (addr=%h)", rd_data, exp_rd, addr);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int hold, input string t);
    @(posedge clk); #2;
    tag = t; addr = a; wr_data = d; wr_en = 1'b1;
    for (int i = 0; i < hold; i++) begin @(posedge clk); #2; end
    wr_en = 1'b0;
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string t);
    @(posedge clk); #2;
    tag = t; addr = a;
    @(posedge clk); #2;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2 started = 1'b1;                 // R1: reset state checked while held
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(BASE, "R1");
    wr(BASE,     32'hA5A5_0F0F, 1, "R2");
    rd(BASE,     "R2");
    wr(BASE + 1, 32'h0000_0F00, 1, "R3");
    wr(BASE + 1, 32'hFFFF_0000, 1, "R3");
    rd(BASE + 1, "R8");
    wr(BASE + 2, 32'h1234_0000, 1, "R4");
    wr(BASE + 2, 32'h0000_00F0, 1, "R6");
    rd(BASE + 2, "R8");
    wr(BASE + 3, 32'hFFFF_FFFF, 1, "R5");
    wr(BASE + 3, 32'h8000_0001, 4, "R7");   // held enable toggles once
    rd(BASE + 3, "R8");
    wr(BASE + 4, 32'hDEAD_BEEF, 1, "R9");   // outside the window
    wr(BASE - 1, 32'hFFFF_FFFF, 1, "R9");
    rd(BASE + 5, "R8");
    wr(BASE,     32'h0000_0000, 3, "R7");
    wr(BASE + 2, 32'hFFFF_FFFF, 2, "R4");
    wr(BASE + 1, 32'h5555_5555, 1, "R6");
    repeat (5) begin @(posedge clk); #2; tag = "R10"; end
    rd(BASE, "R10");
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule